// File: doc/BRIEF.md
# Return-Address Stack with Carry Save

This block is the hardware return stack of a small processor core. Every subroutine call and every interrupt entry pushes the current program counter together with the carry flag as one entry. Each return pops one entry. The core picks one of two kinds of return. One kind hands back both the saved address and the saved carry. The other kind hands back only the address, and the carry flag in the core is left alone.

The stack is a row of registers that shift. The top entry always sits at the outputs, so a return needs no extra read cycle. When a push arrives and every level is already in use, the oldest entry falls off the bottom and is lost. The push itself is never refused. A pop moves every level up by one, and the bottom level keeps its own value. An occupancy count, capped at the number of levels, is brought out for status.

Top module: `ret_stack`

## Requirements
- R1: While reset (`rst_n` low) is sampled at a clock edge, every level clears to zero and `depth_o` becomes 0. After reset, `ret_pc_o`, `ret_cy_o` and `cy_load_o` (with no pop requested) read 0.
- R2: A push loads `{cy_i, pc_i}` into the top level. The carry goes to entry bit 12 and the PC to bits 11..0. From the next cycle, `ret_cy_o` and `ret_pc_o` show this entry, and `depth_o` rises by one unless it is already 4.
- R3: Entries come back in last-in, first-out order. After a pop, the outputs show the entry that was pushed before the one just removed.
- R4: A pop with `pop_cy_i`=1 (return that restores the carry) drives `cy_load_o` high in the same cycle. `ret_cy_o` then carries the saved carry of the entry being returned.
- R5: A pop with `pop_cy_i`=0 (return that keeps the carry) leaves `cy_load_o` low. Only the address is handed back.
- R6: A push while `depth_o`=4 shifts the bottom entry out and loses it. After five pushes, four pops return the 5th, 4th, 3rd and 2nd entries. The 1st entry is gone.
- R7: `depth_o` never exceeds 4, never goes below 0, and falls by one on each pop taken while it is nonzero.
- R8: A pop while `depth_o`=0 keeps `depth_o` at 0. The levels still move up, and the bottom level keeps its value, so repeated pops on an empty stack end up returning the bottom entry.
- R9: When `push_i` and `pop_i` are high in the same cycle, the push is carried out and the pop is ignored: `cy_load_o` stays low and `depth_o` acts as for a push alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Save `{cy_i, pc_i}` on top (call or interrupt entry) |
| pc_i | input | 12 | Program counter to save |
| cy_i | input | 1 | Carry flag to save |
| pop_i | input | 1 | Return: remove the top entry |
| pop_cy_i | input | 1 | Return kind: 1 restores carry, 0 keeps it |
| ret_pc_o | output | 12 | PC field of the top entry |
| ret_cy_o | output | 1 | Carry field of the top entry |
| cy_load_o | output | 1 | Core must load `ret_cy_o` into its carry flag this cycle |
| depth_o | output | 3 | Number of live entries, 0 to 4 |

## Verification
A wrong level register, or a wrong shift direction, changes `ret_pc_o` and `ret_cy_o` one cycle after the push or pop that caused it. If the fault sits in a level below the top, it shows only after enough pops have moved that level up to the outputs. That can take up to three further returns. A bad occupancy counter shows on `depth_o` in the cycle after the operation. A fault in deciding which return kind was requested shows at once on `cy_load_o`, in the same cycle as the pop. Long mixed sweeps of pushes and pops, with the depth driven to both limits, bring every level up to the outputs many times over.

// File: rtl/ret_stack_pkg.sv
// Package: shared constants and the return-kind encoding for the return stack.
// Assumes: entries place the carry directly above the PC field.
package ret_stack_pkg;
    localparam int unsigned DEF_PC_W  = 12;
    localparam int unsigned DEF_DEPTH = 4;

    // Return kind as driven on pop_cy_i.
    typedef enum logic {
        RET_PC_ONLY = 1'b0,
        RET_PC_CY   = 1'b1
    } ret_kind_e;
endpackage

// File: rtl/ret_stack_level.sv
// One level of the shift-register stack.
// What it does: loads the level above on a push, loads the level below on a pop,
// otherwise holds. Assumes push and pop never reach it together (the top resolves that).
module ret_stack_level #(
    parameter int unsigned EW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_dn,
    input  logic          shift_up,
    input  logic [EW-1:0] from_above,
    input  logic [EW-1:0] from_below,
    output logic [EW-1:0] q
);
    // Level register: reset clear, push takes above, pop takes below.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_dn) q <= from_above;
        else if (shift_up) q <= from_below;
    end
endmodule

// File: rtl/ret_stack_occ.sv
// Occupancy counter for the return stack.
// What it does: counts up on push (saturating at MAX) and down on pop (floored at 0).
// Assumes inc and dec are mutually exclusive.
module ret_stack_occ #(
    parameter int unsigned MAX = 4,
    localparam int unsigned CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CMAX = CW'(MAX);

    // Count register with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt <= '0;
        else if (inc && cnt != CMAX)       cnt <= cnt + 1'b1;
        else if (dec && cnt != '0)         cnt <= cnt - 1'b1;
    end

    p_occ_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);
    p_occ_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == CMAX) |=> cnt == CMAX);
    p_occ_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
    p_occ_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/ret_stack.sv
// Return stack with carry save (top).
// What it does: keeps DEPTH entries of {carry, PC}. A push shifts every level down and
// drops the bottom. A pop shifts every level up and the bottom keeps its value. The top
// entry drives the outputs. Push wins over a pop in the same cycle.
// Assumes the core samples ret_* in the cycle it asserts pop_i.
module ret_stack #(
    parameter int unsigned PC_W  = ret_stack_pkg::DEF_PC_W,
    parameter int unsigned DEPTH = ret_stack_pkg::DEF_DEPTH,
    localparam int unsigned EW = PC_W + 1,
    localparam int unsigned DW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [PC_W-1:0] pc_i,
    input  logic            cy_i,
    input  logic            pop_i,
    input  logic            pop_cy_i,
    output logic [PC_W-1:0] ret_pc_o,
    output logic            ret_cy_o,
    output logic            cy_load_o,
    output logic [DW-1:0]   depth_o
);
    import ret_stack_pkg::*;

    logic          do_push;
    logic          do_pop;
    logic [EW-1:0] lvl_q [DEPTH];

    // Operation select: a push masks a pop in the same cycle.
    always_comb begin
        do_push = push_i;
        do_pop  = pop_i && !push_i;
    end

    // One level per stack position; the ends take the new entry or themselves.
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [EW-1:0] above;
        logic [EW-1:0] below;
        if (i == 0) begin : g_top
            assign above = {cy_i, pc_i};
        end else begin : g_mid_a
            assign above = lvl_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_bot
            assign below = lvl_q[i];
        end else begin : g_mid_b
            assign below = lvl_q[i+1];
        end
        ret_stack_level #(.EW(EW)) u_lvl (
            .clk        (clk),
            .rst_n      (rst_n),
            .shift_dn   (do_push),
            .shift_up   (do_pop),
            .from_above (above),
            .from_below (below),
            .q          (lvl_q[i])
        );
    end

    ret_stack_occ #(.MAX(DEPTH)) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (do_push),
        .dec   (do_pop),
        .cnt   (depth_o)
    );

    // Output drive: top entry split into its fields, carry strobe per return kind.
    always_comb begin
        ret_pc_o  = lvl_q[0][PC_W-1:0];
        ret_cy_o  = lvl_q[0][EW-1];
        cy_load_o = do_pop && (ret_kind_e'(pop_cy_i) == RET_PC_CY);
    end

    p_push_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> ({ret_cy_o, ret_pc_o} == {$past(cy_i), $past(pc_i)}));
    p_pop_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> ({ret_cy_o, ret_pc_o} == $past(lvl_q[1])));
    p_no_load_on_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !cy_load_o);
    p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(DEPTH));
    p_bottom_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-1]));
    p_bottom_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> lvl_q[DEPTH-1] == $past(lvl_q[DEPTH-2]));
endmodule

// File: tb/ret_stack_tb_top.sv
// Bench for ret_stack: directed corner cases plus a long pseudo-random sweep of
// push / pop / return-kind combinations compared against an arithmetic shift model.
module ret_stack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [11:0] pc_i = '0;
    logic        cy_i = 1'b0;
    logic        pop_i = 1'b0;
    logic        pop_cy_i = 1'b0;
    logic [11:0] ret_pc_o;
    logic        ret_cy_o;
    logic        cy_load_o;
    logic [2:0]  depth_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [12:0] m [4];
    int md = 0;

    always #4 clk = ~clk;

    ret_stack dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pc_i(pc_i), .cy_i(cy_i),
        .pop_i(pop_i), .pop_cy_i(pop_cy_i), .ret_pc_o(ret_pc_o), .ret_cy_o(ret_cy_o),
        .cy_load_o(cy_load_o), .depth_o(depth_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_i = 0; pop_i = 0; pop_cy_i = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m[i] = '0;
        md = 0;
    endtask

    // Drive one operation, check the same-cycle strobe, then the registered state.
    task automatic do_op(input logic p, input logic q, input logic c,
                         input logic [11:0] pc, input logic cy, input string req);
        push_i = p; pop_i = q; pop_cy_i = c; pc_i = pc; cy_i = cy;
        #1;
        chk((q && c && !p) ? "R4" : (p ? "R9" : "R5"), int'(cy_load_o), int'(q && c && !p));
        @(posedge clk);
        if (p) begin
            for (int i = 3; i > 0; i--) m[i] = m[i-1];
            m[0] = {cy, pc};
            if (md < 4) md++;
        end else if (q) begin
            for (int i = 0; i < 3; i++) m[i] = m[i+1];
            if (md > 0) md--;
        end
        @(negedge clk);
        push_i = 0; pop_i = 0; pop_cy_i = 0;
        chk(req, int'({ret_cy_o, ret_pc_o}), int'(m[0]));
        chk("R7", int'(depth_o), md);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] seed;
        do_reset();
        // R1: reset state
        chk("R1", int'(depth_o), 0);
        chk("R1", int'({ret_cy_o, ret_pc_o}), 0);
        #1;
        chk("R1", int'(cy_load_o), 0);

        // R2 / R6: five pushes, bottom lost
        for (int k = 1; k <= 5; k++) begin
            do_op(1, 0, 0, 12'(k * 12'h111), k[0], "R2");
        end
        chk("R6", int'(depth_o), 4);
        chk("R6", int'({ret_cy_o, ret_pc_o}), int'({1'b1, 12'h555}));
        do_op(0, 1, 1, 0, 0, "R3");
        chk("R3", int'({ret_cy_o, ret_pc_o}), int'({1'b0, 12'h444}));
        do_op(0, 1, 0, 0, 0, "R5");
        chk("R3", int'({ret_cy_o, ret_pc_o}), int'({1'b1, 12'h333}));
        do_op(0, 1, 1, 0, 0, "R4");
        chk("R6", int'({ret_cy_o, ret_pc_o}), int'({1'b0, 12'h222}));
        do_op(0, 1, 1, 0, 0, "R6");
        chk("R6", int'({ret_cy_o, ret_pc_o}), int'({1'b0, 12'h222}));
        chk("R7", int'(depth_o), 0);
        // R8: pops on empty stay at depth 0, return bottom entry
        do_op(0, 1, 1, 0, 0, "R8");
        do_op(0, 1, 0, 0, 0, "R8");
        chk("R8", int'(depth_o), 0);
        chk("R8", int'({ret_cy_o, ret_pc_o}), int'({1'b0, 12'h222}));
        // R9: push and pop together
        do_op(1, 1, 1, 12'hABC, 1, "R9");
        chk("R9", int'(depth_o), 1);
        chk("R9", int'({ret_cy_o, ret_pc_o}), int'({1'b1, 12'hABC}));

        // Mid-run reset, then sweep
        do_reset();
        chk("R1", int'(depth_o), 0);
        seed = 32'h1234_5678;
        for (int s = 0; s < 3000; s++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            do_op(seed[16], seed[17], seed[18], seed[30:19], seed[31], "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule